// File: doc/BRIEF.md
# Split Completion Error Translator

This block sits on the return path of a bridge that forwards requests from a PCIe link to a PCI-X bus. A PCI-X target that answered with a split response may later report that it could not finish the transaction. It does so by sending a split completion message that carries a completer-error class and index. The translator decodes each such message into the PCIe completion status that goes back to the original requester. It also sets sticky error bits in two registers: a secondary status register and a secondary uncorrectable error status register.

When an uncorrectable error is not masked, the block captures the request header into a log register and loads a first-error pointer with the bit position of that error. The log and the pointer then stay frozen until software clears the status bit they point at. Software clears any status bit by pulsing its write-one-to-clear strobe.

Top module: `sce_xlate`

## Requirements
- R1: `cpl_valid` is high exactly one cycle after `msg_valid`. `cpl_status` then holds the status code: 3'b000 is successful, 3'b001 is Unsupported Request (UR) and 3'b100 is Completer Abort (CA). `cpl_status` is 3'b000 whenever `cpl_valid` is low.
- R2: Class 1 with index 0x00 (master abort) returns UR. It sets `sec_status[3]` (received master abort) and `unc_status[1]` (received master abort).
- R3: Class 1 with index 0x01 (target abort) returns CA. It sets `sec_status[2]` (received target abort) and `unc_status[0]` (received target abort).
- R4: Two messages are data errors: class 1 with index 0x02 (write data error) and class 2 with index 0x01 (split write data error). Each returns UR and sets `sec_status[0]` (master data parity error) and `unc_status[2]` (parity error signal seen).
- R5: Class 2 with index 0x00 (byte count out of range) returns UR and sets no status bit. Class 2 with an index in 0x80 to 0x8F (device specific) returns CA. Every class and index pair not named in R2 to R5 also returns CA. Neither of these CA cases sets any bit other than the one in R6.
- R6: Every CA return also sets `sec_status[1]` (signalled target abort), in the same cycle as `cpl_valid`.
- R7: Status bits are sticky. A bit is cleared by a one on the matching bit of `sec_clr` or `unc_clr`. If a new error sets the same bit in the same cycle as the clear, the set wins.
- R8: Suppose an uncorrectable error arrives whose `unc_mask` bit is 0, while no log is held. The next cycle then shows the header in `hdr_log`, the error's `unc_status` bit number in `err_ptr`, and `ptr_valid` high. `err_report` pulses high for that one cycle for every unmasked uncorrectable error.
- R9: An uncorrectable error whose mask bit is 1 still sets its status bit. It does not capture the header, it does not set `ptr_valid` and it does not pulse `err_report`.
- R10: While `ptr_valid` is high, `hdr_log` and `err_ptr` do not change. They are released only when the `unc_status` bit that `err_ptr` names is cleared, and that clear drops `ptr_valid`.
- R11: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_valid | input | 1 | Split completion error message present |
| msg_class | input | CLS_W | Completer error class |
| msg_index | input | IDX_W | Completer error index |
| msg_header | input | HDR_W | Header of the affected request |
| unc_mask | input | 3 | Per-bit mask for the uncorrectable status bits |
| sec_clr | input | 4 | Write-one-to-clear strobes for the secondary status bits |
| unc_clr | input | 3 | Write-one-to-clear strobes for the uncorrectable status bits |
| cpl_valid | output | 1 | Completion status valid |
| cpl_status | output | 3 | PCIe completion status code |
| sec_status | output | 4 | Secondary status bits |
| unc_status | output | 3 | Secondary uncorrectable error status bits |
| hdr_log | output | HDR_W | Logged header of the first unmasked error |
| err_ptr | output | 2 | Bit number of the first unmasked error |
| ptr_valid | output | 1 | Header log and pointer are held |
| err_report | output | 1 | Pulse for an unmasked uncorrectable error |

## Verification
The bench sends every combination of classes 0 to 3 and all 256 indices, clearing both registers between messages. This sweep separates each named pair from its neighbours, and it catches decodes that match too many index bits, such as the 0x8X range or index 0x02 in class 2. Separate sequences then test the logging path:
- An unmasked master abort followed by a target abort shows whether the log stays frozen.
- A clear of the wrong bit against a clear of the pointed-to bit shows that the release depends on the pointer.
- A masked error shows that the mask gates capture and reporting but not the status bit.
- A clear that arrives with a new error on the same bit shows the set-wins priority.

// File: rtl/sce_xlate.sv
module sce_xlate #(
  parameter int HDR_W = 32,
  parameter int CLS_W = 4,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [CLS_W-1:0] msg_class,
  input  logic [IDX_W-1:0] msg_index,
  input  logic [HDR_W-1:0] msg_header,
  input  logic [2:0]       unc_mask,
  input  logic [3:0]       sec_clr,
  input  logic [2:0]       unc_clr,
  output logic             cpl_valid,
  output logic [2:0]       cpl_status,
  output logic [3:0]       sec_status,
  output logic [2:0]       unc_status,
  output logic [HDR_W-1:0] hdr_log,
  output logic [1:0]       err_ptr,
  output logic             ptr_valid,
  output logic             err_report
);
  localparam logic [2:0] ST_UR = 3'b001;
  localparam logic [2:0] ST_CA = 3'b100;

  logic [2:0] dec_st;
  logic [3:0] dec_sec;
  logic [2:0] dec_unc;

  always_comb begin
    dec_st  = ST_CA;
    dec_sec = '0;
    dec_unc = '0;
    if (msg_class == CLS_W'(1)) begin
      if (msg_index == IDX_W'(0)) begin
        dec_st = ST_UR; dec_sec[3] = 1'b1; dec_unc[1] = 1'b1;
      end else if (msg_index == IDX_W'(1)) begin
        dec_sec[2] = 1'b1; dec_unc[0] = 1'b1;
      end else if (msg_index == IDX_W'(2)) begin
        dec_st = ST_UR; dec_sec[0] = 1'b1; dec_unc[2] = 1'b1;
      end
    end else if (msg_class == CLS_W'(2)) begin
      if (msg_index == IDX_W'(0)) begin
        dec_st = ST_UR;
      end else if (msg_index == IDX_W'(1)) begin
        dec_st = ST_UR; dec_sec[0] = 1'b1; dec_unc[2] = 1'b1;
      end
    end
    dec_sec[1] = (dec_st == ST_CA);
  end

  logic [3:0] sec_hit;
  logic [2:0] unc_hit, unc_live;
  logic [1:0] ptr_n;
  logic       release_log, capture;

  assign sec_hit     = msg_valid ? dec_sec : 4'b0;
  assign unc_hit     = msg_valid ? dec_unc : 3'b0;
  assign unc_live    = unc_hit & ~unc_mask;
  assign ptr_n       = unc_live[2] ? 2'd2 : (unc_live[1] ? 2'd1 : 2'd0);
  assign release_log = ptr_valid && unc_clr[err_ptr];
  assign capture     = (|unc_live) && (!ptr_valid || release_log);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpl_valid  <= 1'b0;
      cpl_status <= '0;
      sec_status <= '0;
      unc_status <= '0;
      hdr_log    <= '0;
      err_ptr    <= '0;
      ptr_valid  <= 1'b0;
      err_report <= 1'b0;
    end else begin
      cpl_valid  <= msg_valid;
      cpl_status <= msg_valid ? dec_st : 3'b000;
      sec_status <= (sec_status & ~sec_clr) | sec_hit;
      unc_status <= (unc_status & ~unc_clr) | unc_hit;
      err_report <= |unc_live;
      if (capture) begin
        hdr_log   <= msg_header;
        err_ptr   <= ptr_n;
        ptr_valid <= 1'b1;
      end else if (release_log) begin
        ptr_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sce_xlate_chk.sv
module sce_xlate_chk #(
  parameter int HDR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic [2:0]       unc_clr,
  input logic [3:0]       sec_clr,
  input logic             cpl_valid,
  input logic [2:0]       cpl_status,
  input logic [3:0]       sec_status,
  input logic [2:0]       unc_status,
  input logic [HDR_W-1:0] hdr_log,
  input logic [1:0]       err_ptr,
  input logic             ptr_valid,
  input logic             err_report
);
  AST_CPL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> cpl_valid); // R1
  AST_CPL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cpl_valid |-> cpl_status == 3'b000); // R1
  AST_CA_SETS_STA: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_status == 3'b100) |-> sec_status[1]); // R6
  AST_SEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sec_status) & ~$past(sec_clr)) & ~sec_status) == 4'b0); // R7
  AST_UNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(unc_status) & ~$past(unc_clr)) & ~unc_status) == 3'b0); // R7
  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_valid && !unc_clr[err_ptr]) |=> (ptr_valid && $stable(hdr_log) && $stable(err_ptr))); // R10
  AST_PTR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_valid |-> unc_status[err_ptr]); // R10
  AST_REPORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    err_report |-> ptr_valid); // R8
endmodule

bind sce_xlate sce_xlate_chk #(.HDR_W(HDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .unc_clr(unc_clr), .sec_clr(sec_clr),
  .cpl_valid(cpl_valid), .cpl_status(cpl_status), .sec_status(sec_status),
  .unc_status(unc_status), .hdr_log(hdr_log), .err_ptr(err_ptr),
  .ptr_valid(ptr_valid), .err_report(err_report)
);

// File: tb/test_sce_xlate.sv
`timescale 1ns/1ps
module test_sce_xlate;
  localparam int HDR_W = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic msg_valid = 1'b0;
  logic [3:0] msg_class = '0;
  logic [7:0] msg_index = '0;
  logic [HDR_W-1:0] msg_header = '0;
  logic [2:0] unc_mask = '0, unc_clr = '0;
  logic [3:0] sec_clr = '0;
  logic cpl_valid, ptr_valid, err_report;
  logic [2:0] cpl_status, unc_status;
  logic [3:0] sec_status;
  logic [HDR_W-1:0] hdr_log;
  logic [1:0] err_ptr;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sce_xlate #(.HDR_W(HDR_W)) i_sce_xlate (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_class(msg_class),
    .msg_index(msg_index), .msg_header(msg_header), .unc_mask(unc_mask),
    .sec_clr(sec_clr), .unc_clr(unc_clr), .cpl_valid(cpl_valid),
    .cpl_status(cpl_status), .sec_status(sec_status), .unc_status(unc_status),
    .hdr_log(hdr_log), .err_ptr(err_ptr), .ptr_valid(ptr_valid), .err_report(err_report));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] expect_of(logic [3:0] c, logic [7:0] i);
    logic [2:0] st = 3'b100; logic [3:0] s = 4'b0; logic [2:0] u = 3'b0;
    if (c == 1 && i == 0) begin st = 3'b001; s[3] = 1; u[1] = 1; end
    else if (c == 1 && i == 1) begin s[2] = 1; u[0] = 1; end
    else if ((c == 1 && i == 2) || (c == 2 && i == 1)) begin st = 3'b001; s[0] = 1; u[2] = 1; end
    else if (c == 2 && i == 0) st = 3'b001;
    if (st == 3'b100) s[1] = 1;
    return {st, s, u};
  endfunction

  task automatic send(logic [3:0] c, logic [7:0] i, logic [HDR_W-1:0] h);
    @(negedge clk);
    msg_valid = 1; msg_class = c; msg_index = i; msg_header = h;
    @(negedge clk);
    msg_valid = 0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    sec_clr = '1; unc_clr = '1;
    @(negedge clk);
    sec_clr = '0; unc_clr = '0;
  endtask

  initial begin
    #5_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [9:0] e;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", {cpl_valid, cpl_status, sec_status, unc_status, ptr_valid, err_report, err_ptr}, 0);
    check("R11", hdr_log, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle", {cpl_valid, cpl_status}, 0);

    // Sweep R2 R3 R4 R5 R6, with mask all on so logging stays out of the way
    unc_mask = '1;
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 256; i++) begin
        e = expect_of(4'(c), 8'(i));
        send(4'(c), 8'(i), 32'(c * 256 + i));
        check("R1 valid", cpl_valid, 1);
        check("R2 R3 R4 R5 status", cpl_status, e[9:7]);
        check("R2 R3 R4 R5 R6 sec", sec_status, e[6:3]);
        check("R2 R3 R4 R9 unc", unc_status, e[2:0]);
        check("R9 no report", {ptr_valid, err_report}, 0);
        @(negedge clk);
        check("R1 one cycle", {cpl_valid, cpl_status}, 0);
        check("R7 sticky", {sec_status, unc_status}, {e[6:3], e[2:0]});
        clear_all();
        check("R7 cleared", {sec_status, unc_status}, 0);
      end
    end

    // R8 capture
    unc_mask = '0;
    send(1, 0, 32'hA5A5_0001);
    check("R8 report", err_report, 1);
    check("R8 ptr", {ptr_valid, err_ptr}, {1'b1, 2'd1});
    check("R8 hdr", hdr_log, 32'hA5A5_0001);
    @(negedge clk);
    check("R8 pulse", err_report, 0);
    // R10 frozen by later error
    send(1, 1, 32'hBEEF_0002);
    check("R10 report", err_report, 1);
    check("R10 ptr", {ptr_valid, err_ptr}, {1'b1, 2'd1});
    check("R10 hdr", hdr_log, 32'hA5A5_0001);
    check("R10 unc", unc_status, 3'b011);
    // clearing the other bit does not release
    @(negedge clk); unc_clr = 3'b001; @(negedge clk); unc_clr = 0;
    check("R10 other clr", {ptr_valid, err_ptr, unc_status}, {1'b1, 2'd1, 3'b010});
    check("R10 other clr hdr", hdr_log, 32'hA5A5_0001);
    @(negedge clk); unc_clr = 3'b010; @(negedge clk); unc_clr = 0;
    check("R10 release", {ptr_valid, unc_status}, 0);
    // new capture after release
    send(2, 1, 32'h1234_5678);
    check("R8 recapture", {ptr_valid, err_ptr}, {1'b1, 2'd2});
    check("R8 recapture hdr", hdr_log, 32'h1234_5678);
    clear_all();
    check("R10 cleared", ptr_valid, 0);

    // R9 masked error
    unc_mask = 3'b010;
    send(1, 0, 32'hDEAD_0003);
    check("R9 masked", {ptr_valid, err_report}, 0);
    check("R9 bit still set", unc_status, 3'b010);
    check("R9 hdr kept", hdr_log, 32'h1234_5678);
    clear_all();

    // R7 set wins over clear in the same cycle
    unc_mask = '1;
    send(1, 1, 0);
    @(negedge clk);
    msg_valid = 1; msg_class = 1; msg_index = 1; sec_clr = '1; unc_clr = '1;
    @(negedge clk);
    msg_valid = 0; sec_clr = 0; unc_clr = 0;
    check("R7 set wins sec", sec_status, 4'b0110);
    check("R7 set wins unc", unc_status, 3'b001);
    clear_all();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule